// File: doc/BRIEF.md
# Segmented Highly-Associative Cache Controller

This block is a 16 KB read cache that sits between a CPU data port and a slower backing memory. The storage holds 512 lines. Each line has eight 32-bit words. The lines are split into 8 segments, and each segment has 64 ways. Address bits pick the segment and the word within the line. The upper address bits form the tag, which is compared in parallel against all 64 ways of the chosen segment.

A cacheable read that hits is answered from the cache. A cacheable read that misses fetches the whole line from memory as one 8-beat burst, in ascending word order. The fill overwrites a victim way, and the requested word is returned once the burst ends. Writes are write-through with no allocation. An access marked non-cacheable goes straight to memory as a single-word transfer.

Victims are picked in one of two ways:
- **Random:** from a free-running LFSR. This mode is active after reset.
- **Round-robin:** from a pointer that each segment keeps separately.

A lockdown base shields the ways numbered below it from eviction, in steps of one way, which is 1/64 of the cache.

Top module: `seg_assoc_cache`

## Requirements
- R1: After reset all lines are invalid, the replacement mode is random and the lockdown base is 0. `resp_ready` and `mem_req` are low, and the first cacheable read of any address performs a line fill.
- R2: A cacheable read that hits returns the stored word with `resp_ready` high exactly two cycles after the request cycle. It starts no memory transfer.
- R3: A cacheable read miss raises `mem_req` with `mem_burst`=1. `mem_addr` is the address with bits 4:0 cleared, and it is held until the eighth `mem_rvalid` beat. Beat k carries word k. The requested word appears with `resp_ready` in the cycle after the last beat, so with no memory stalls this is WORDS+2 cycles after the request. Afterwards the line hits.
- R4: The address fields are word = bits 4:2, segment = bits 7:5 and tag = bits 31:8. Lines with equal tags in different segments are independent.
- R5: In round-robin mode each segment has its own pointer. Successive misses in a segment evict ways in ascending order. After the top way, the pointer wraps back to the lockdown base. A pointer below the base is treated as the base.
- R6: Ways numbered below the lockdown base are never chosen as victims, in either mode.
- R7: In random mode the victim is the current value of a free-running maximal-length LFSR that is log2(ways) bits wide (x^6+x^5+1 at the default size). A value below the lockdown base is replaced by the base.
- R8: A cacheable write issues exactly one single-word memory write (`mem_burst`=0, `mem_write`=1), and `resp_ready` follows three cycles after the request. On a hit the stored word is updated in the same step. On a miss no line is filled.
- R9: A non-cacheable access performs one single-word memory read or write, with read data returned three cycles after the request. It never allocates a line and never changes cached contents.
- R10: A request is accepted only while the controller is idle, and `req_valid` at other times is ignored. `resp_ready` lasts one cycle. A pulse on `cfg_load` replaces both the mode (`cfg_round_robin`=1 selects round-robin) and the lockdown base for later misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load the replacement configuration |
| cfg_round_robin | input | 1 | 1 = round-robin, 0 = random |
| cfg_lock_base | input | log2(WAYS) | First way that may be evicted |
| req_valid | input | 1 | CPU request strobe |
| req_addr | input | 32 | CPU byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | CPU write data |
| req_cacheable | input | 1 | Access may use the cache |
| resp_ready | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Read data, valid with resp_ready |
| mem_req | output | 1 | Memory transfer active |
| mem_burst | output | 1 | Transfer is a line fill of WORDS beats |
| mem_write | output | 1 | Transfer is a single-word write |
| mem_addr | output | 32 | Transfer address (line-aligned for fills) |
| mem_wdata | output | 32 | Write data to memory |
| mem_rvalid | input | 1 | Memory beat or write acknowledge |
| mem_rdata | input | 32 | Memory read data |

## Verification
A cacheable write that hits does two things in one step: it updates the stored word and it starts the write-through transfer. The bench provokes this by writing to a line known to be resident. It then checks three things:
- exactly one single-word write reached memory with the new data;
- no fill was issued;
- an immediate read of the same address hits in two cycles and returns the new word.

Lookup and victim advance can also coincide with a stray `req_valid` pulse that arrives during a fill. The bench judges that case by the absence of any extra transfer or response.

// File: rtl/segcache_pkg.sv
package segcache_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FILL,
        ST_SINGLE
    } cc_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [DATA_W-1:0] wdata;
        logic              cacheable;
    } cpu_req_t;

    // Fibonacci feedback taps for maximal-length sequences of small widths
    function automatic logic [7:0] lfsr_taps(input int width);
        case (width)
            2:       return 8'b0000_0011;
            3:       return 8'b0000_0110;
            4:       return 8'b0000_1100;
            5:       return 8'b0001_0100;
            6:       return 8'b0011_0000;
            7:       return 8'b0110_0000;
            default: return 8'b1011_1000;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a,
                                                      input int bits);
        return a & ~((ADDR_W'(1) << bits) - ADDR_W'(1));
    endfunction

endpackage

// File: rtl/cache_lfsr.sv
module cache_lfsr #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] value
);
    import segcache_pkg::*;

    localparam logic [W-1:0] TAPS = W'(lfsr_taps(W));

    logic [W-1:0] q;
    logic         fb;

    assign fb    = ^(q & TAPS);
    assign value = q;

    always_ff @(posedge clk) begin
        if (rst) q <= W'(1);
        else     q <= {q[W-2:0], fb};
    end

    // R7: the generator never locks up in the all-zero state
    p_lfsr_nonzero_r7: assert property (@(posedge clk) disable iff (rst) q != '0)
        else $error("lfsr reached zero");

endmodule

// File: rtl/cache_victim.sv
module cache_victim #(
    parameter int WAYS = 64,
    parameter int SEGS = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    round_robin,
    input  logic [$clog2(WAYS)-1:0] lock_base,
    input  logic [$clog2(WAYS)-1:0] rand_val,
    input  logic [$clog2(SEGS)-1:0] seg,
    input  logic                    advance,
    output logic [$clog2(WAYS)-1:0] victim
);
    localparam int WAY_W = $clog2(WAYS);
    localparam logic [WAY_W-1:0] TOP_WAY = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] ptr_q [SEGS];
    logic [WAY_W-1:0] rr_way;
    logic [WAY_W-1:0] rr_next;
    logic [WAY_W-1:0] rnd_way;

    always_comb begin
        rr_way  = (ptr_q[seg] < lock_base) ? lock_base : ptr_q[seg];
        rr_next = (rr_way == TOP_WAY) ? lock_base : rr_way + WAY_W'(1);
        rnd_way = (rand_val < lock_base) ? lock_base : rand_val;
        victim  = round_robin ? rr_way : rnd_way;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SEGS; s++) ptr_q[s] <= '0;
        end else if (advance && round_robin) begin
            ptr_q[seg] <= rr_next;
        end
    end

    // R5: leaving the top way sends the segment pointer back to the lock base
    p_rr_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (advance && round_robin && victim == TOP_WAY) |=> ptr_q[$past(seg)] == $past(lock_base))
        else $error("round-robin pointer did not wrap to lock base");

endmodule

// File: rtl/cache_tags.sv
module cache_tags #(
    parameter int WAYS  = 64,
    parameter int SEGS  = 8,
    parameter int TAG_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [$clog2(SEGS)-1:0] look_seg,
    input  logic [TAG_W-1:0]        look_tag,
    output logic                    hit,
    output logic [$clog2(WAYS)-1:0] hit_way,
    input  logic                    wr_en,
    input  logic [$clog2(SEGS)-1:0] wr_seg,
    input  logic [$clog2(WAYS)-1:0] wr_way,
    input  logic [TAG_W-1:0]        wr_tag
);
    localparam int WAY_W = $clog2(WAYS);

    logic [TAG_W-1:0] tag_q   [SEGS][WAYS];
    logic [WAYS-1:0]  valid_q [SEGS];
    logic [WAYS-1:0]  match;

    always_comb begin
        match   = '0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (valid_q[look_seg][w] && tag_q[look_seg][w] == look_tag) begin
                match[w] = 1'b1;
                hit_way  = WAY_W'(w);
            end
        end
        hit = |match;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SEGS; s++) valid_q[s] <= '0;
        end else if (wr_en) begin
            valid_q[wr_seg][wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_seg][wr_way] <= wr_tag;
    end

    // R3: a fill only follows a miss, so no tag is ever resident twice in a segment
    p_one_match_r3: assert property (@(posedge clk) disable iff (rst) $onehot0(match))
        else $error("tag resident in more than one way");

endmodule

// File: rtl/cache_data.sv
module cache_data #(
    parameter int DEPTH  = 4096,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [DATA_W-1:0]        rdata
);
    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store_q[wr_idx] <= wdata;
    end

    assign rdata = store_q[rd_idx];

endmodule

// File: rtl/seg_assoc_cache.sv
module seg_assoc_cache
    import segcache_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int SEGS  = 8,
    parameter int WAYS  = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_load,
    input  logic                    cfg_round_robin,
    input  logic [$clog2(WAYS)-1:0] cfg_lock_base,
    input  logic                    req_valid,
    input  logic [31:0]             req_addr,
    input  logic                    req_write,
    input  logic [31:0]             req_wdata,
    input  logic                    req_cacheable,
    output logic                    resp_ready,
    output logic [31:0]             resp_rdata,
    output logic                    mem_req,
    output logic                    mem_burst,
    output logic                    mem_write,
    output logic [31:0]             mem_addr,
    output logic [31:0]             mem_wdata,
    input  logic                    mem_rvalid,
    input  logic [31:0]             mem_rdata
);
    localparam int WORD_W = $clog2(WORDS);
    localparam int SEG_W  = $clog2(SEGS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int OFF_W  = 2 + WORD_W;
    localparam int TAG_W  = ADDR_W - OFF_W - SEG_W;
    localparam int DEPTH  = SEGS * WAYS * WORDS;
    localparam int IDX_W  = SEG_W + WAY_W + WORD_W;
    localparam logic [WORD_W-1:0] LAST_BEAT = WORD_W'(WORDS - 1);

    cc_state_t         state_q;
    cpu_req_t          rq;
    logic [WAY_W-1:0]  victim_q;
    logic [WORD_W-1:0] beat_q;
    logic [DATA_W-1:0] capt_q;
    logic              ready_q;
    logic [DATA_W-1:0] rdata_q;
    logic              cfg_rr_q;
    logic [WAY_W-1:0]  cfg_lock_q;

    logic [WORD_W-1:0] word;
    logic [SEG_W-1:0]  seg;
    logic [TAG_W-1:0]  tag;
    logic              hit;
    logic [WAY_W-1:0]  hit_way;
    logic [WAY_W-1:0]  victim;
    logic [WAY_W-1:0]  rand_val;
    logic              is_read_c;
    logic              fill_start;
    logic              fill_last;
    logic              dat_we;
    logic [IDX_W-1:0]  dat_widx;
    logic [DATA_W-1:0] dat_wdata;
    logic [DATA_W-1:0] dat_rdata;

    // field split of the latched address
    assign word = rq.addr[2 +: WORD_W];
    assign seg  = rq.addr[OFF_W +: SEG_W];
    assign tag  = rq.addr[ADDR_W-1 -: TAG_W];

    assign is_read_c  = rq.cacheable && !rq.write;
    assign fill_start = (state_q == ST_LOOKUP) && is_read_c && !hit;
    assign fill_last  = (state_q == ST_FILL) && mem_rvalid && (beat_q == LAST_BEAT);

    cache_lfsr #(.W(WAY_W)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .value (rand_val)
    );

    cache_victim #(.WAYS(WAYS), .SEGS(SEGS)) u_victim (
        .clk         (clk),
        .rst         (rst),
        .round_robin (cfg_rr_q),
        .lock_base   (cfg_lock_q),
        .rand_val    (rand_val),
        .seg         (seg),
        .advance     (fill_start),
        .victim      (victim)
    );

    cache_tags #(.WAYS(WAYS), .SEGS(SEGS), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .look_seg (seg),
        .look_tag (tag),
        .hit      (hit),
        .hit_way  (hit_way),
        .wr_en    (fill_last),
        .wr_seg   (seg),
        .wr_way   (victim_q),
        .wr_tag   (tag)
    );

    always_comb begin
        if (state_q == ST_FILL) begin
            dat_we    = mem_rvalid;
            dat_widx  = {seg, victim_q, beat_q};
            dat_wdata = mem_rdata;
        end else begin
            dat_we    = (state_q == ST_LOOKUP) && rq.write && rq.cacheable && hit;
            dat_widx  = {seg, hit_way, word};
            dat_wdata = rq.wdata;
        end
    end

    cache_data #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
        .clk    (clk),
        .we     (dat_we),
        .wr_idx (dat_widx),
        .wdata  (dat_wdata),
        .rd_idx ({seg, hit_way, word}),
        .rdata  (dat_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            rq         <= '0;
            victim_q   <= '0;
            beat_q     <= '0;
            capt_q     <= '0;
            ready_q    <= 1'b0;
            rdata_q    <= '0;
            cfg_rr_q   <= 1'b0;
            cfg_lock_q <= '0;
        end else begin
            ready_q <= 1'b0;
            if (cfg_load) begin
                cfg_rr_q   <= cfg_round_robin;
                cfg_lock_q <= cfg_lock_base;
            end
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        rq.addr      <= req_addr;
                        rq.write     <= req_write;
                        rq.wdata     <= req_wdata;
                        rq.cacheable <= req_cacheable;
                        state_q      <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (is_read_c && hit) begin
                        rdata_q <= dat_rdata;
                        ready_q <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (is_read_c) begin
                        victim_q <= victim;
                        beat_q   <= '0;
                        state_q  <= ST_FILL;
                    end else begin
                        state_q <= ST_SINGLE;
                    end
                end
                ST_FILL: begin
                    if (mem_rvalid) begin
                        if (beat_q == word) capt_q <= mem_rdata;
                        if (beat_q == LAST_BEAT) begin
                            rdata_q <= (beat_q == word) ? mem_rdata : capt_q;
                            ready_q <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            beat_q <= beat_q + WORD_W'(1);
                        end
                    end
                end
                ST_SINGLE: begin
                    if (mem_rvalid) begin
                        if (!rq.write) rdata_q <= mem_rdata;
                        ready_q <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign resp_ready = ready_q;
    assign resp_rdata = rdata_q;
    assign mem_req    = (state_q == ST_FILL) || (state_q == ST_SINGLE);
    assign mem_burst  = (state_q == ST_FILL);
    assign mem_write  = (state_q == ST_SINGLE) && rq.write;
    assign mem_addr   = (state_q == ST_FILL) ? align_down(rq.addr, OFF_W) : align_down(rq.addr, 2);
    assign mem_wdata  = rq.wdata;

    // R10: completion is a single-cycle pulse
    p_ready_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        resp_ready |=> !resp_ready)
        else $error("resp_ready held longer than one cycle");

    // R3: the transfer is held steady until memory answers
    p_mem_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr) && $stable(mem_burst)))
        else $error("memory request changed before acknowledge");

    // R3: fills start at a line boundary
    p_fill_aligned_r3: assert property (@(posedge clk) disable iff (rst)
        mem_burst |-> (mem_addr[OFF_W-1:0] == '0))
        else $error("fill address not line aligned");

    // R9 and R8: bursts only serve cacheable reads
    p_burst_reads_only_r9: assert property (@(posedge clk) disable iff (rst)
        mem_burst |-> (rq.cacheable && !rq.write))
        else $error("fill issued for write or uncached access");

    // R6: the captured victim respects the lock base in force at selection
    p_victim_unlocked_r6: assert property (@(posedge clk) disable iff (rst)
        fill_start |=> victim_q >= $past(cfg_lock_q))
        else $error("locked way chosen as victim");

endmodule

// File: tb/test_seg_assoc_cache.sv
module test_seg_assoc_cache;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS = 8;
    localparam int SEGS  = 2;
    localparam int WAYS  = 4;
    localparam int WAY_W = $clog2(WAYS);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_load = 1'b0;
    logic             cfg_round_robin = 1'b0;
    logic [WAY_W-1:0] cfg_lock_base = '0;
    logic             req_valid = 1'b0;
    logic [31:0]      req_addr = '0;
    logic             req_write = 1'b0;
    logic [31:0]      req_wdata = '0;
    logic             req_cacheable = 1'b0;
    logic             resp_ready;
    logic [31:0]      resp_rdata;
    logic             mem_req;
    logic             mem_burst;
    logic             mem_write;
    logic [31:0]      mem_addr;
    logic [31:0]      mem_wdata;
    logic             mem_rvalid = 1'b0;
    logic [31:0]      mem_rdata = '0;

    int n_vec = 0;
    int n_bad = 0;
    int n_burst = 0;
    int n_srd = 0;
    int n_swr = 0;
    logic [31:0] last_addr = '0;
    bit stall_en = 0;

    logic [31:0] bmem [logic [31:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_assoc_cache #(.WORDS(WORDS), .SEGS(SEGS), .WAYS(WAYS)) i_seg_assoc_cache (
        .clk(clk), .rst(rst),
        .cfg_load(cfg_load), .cfg_round_robin(cfg_round_robin), .cfg_lock_base(cfg_lock_base),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_wdata(req_wdata), .req_cacheable(req_cacheable),
        .resp_ready(resp_ready), .resp_rdata(resp_rdata),
        .mem_req(mem_req), .mem_burst(mem_burst), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        if (bmem.exists(a)) return bmem[a];
        return a ^ (a << 13) ^ 32'h5A00_00C3;
    endfunction

    function automatic logic [31:0] mk(input int tag, input int seg, input int word);
        return (32'(tag) << 6) | (32'(seg) << 5) | (32'(word) << 2);
    endfunction

    // backing memory: one beat per cycle, optionally every other cycle
    initial begin
        int  cnt = 0;
        bit  seen = 0;
        bit  ph = 0;
        forever begin
            @(negedge clk);
            if (!mem_req) begin
                cnt = 0; seen = 0; mem_rvalid = 1'b0;
            end else begin
                int need;
                if (!seen) begin
                    seen = 1;
                    last_addr = mem_addr;
                    if (mem_burst) n_burst++;
                    else if (mem_write) n_swr++;
                    else n_srd++;
                end
                need = mem_burst ? WORDS : 1;
                ph = ~ph;
                if (cnt < need && !(stall_en && ph)) begin
                    logic [31:0] a;
                    a = mem_addr + 32'(4 * cnt);
                    if (mem_write) bmem[a] = mem_wdata;
                    mem_rdata  = mem_val(a);
                    mem_rvalid = 1'b1;
                    cnt++;
                end else begin
                    mem_rvalid = 1'b0;
                end
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cfg(input bit rr, input int lock);
        @(negedge clk);
        cfg_load = 1'b1; cfg_round_robin = rr; cfg_lock_base = WAY_W'(lock);
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic access(input logic [31:0] a, input logic we, input logic [31:0] wd,
                          input logic cach, output logic [31:0] rd, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = we; req_wdata = wd; req_cacheable = cach;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_ready && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        rd = resp_rdata;
    endtask

    task automatic rd_chk(input string what, input logic [31:0] a, input bit exp_hit);
        int b0;
        int lat;
        logic [31:0] d;
        logic [31:0] e;
        b0 = n_burst;
        e  = mem_val(a);
        access(a, 1'b0, '0, 1'b1, d, lat);
        chk({what, " data"}, d, e);
        if (exp_hit) begin
            chk({what, " hit latency"}, 32'(lat), 32'd2);
            chk({what, " no fill on hit"}, 32'(n_burst - b0), 32'd0);
        end else begin
            chk({what, " one fill on miss"}, 32'(n_burst - b0), 32'd1);
            chk({what, " fill address"}, last_addr, a & ~32'h1F);
            if (!stall_en) chk({what, " miss latency"}, 32'(lat), 32'(WORDS + 2));
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] old;
        int lat;
        int b0, w0, r0;

        do_reset();
        // R1: idle outputs after reset
        chk("R1 resp_ready after reset", 32'(resp_ready), 32'd0);
        chk("R1 mem_req after reset", 32'(mem_req), 32'd0);

        // R3 / R4 / R2: sweep every word of both segments, second segment with stalls
        for (int s = 0; s < SEGS; s++) begin
            stall_en = (s == 1);
            for (int w = 0; w < WORDS; w++)
                rd_chk($sformatf("R4 seg%0d word%0d", s, w), mk(7, s, w), w != 0);
        end
        stall_en = 0;
        // R3: refetch of line starting from a middle word: first word requested is 5
        rd_chk("R3 mid-word miss", mk(9, 0, 5), 1'b0);
        rd_chk("R2 hit after mid-word fill", mk(9, 0, 0), 1'b1);

        // R1: reset invalidates previously resident lines
        do_reset();
        rd_chk("R1 miss after reset", mk(7, 0, 0), 1'b0);

        // R5: per-segment round-robin pointers and wrap
        do_reset();
        cfg(1'b1, 0);
        for (int t = 1; t <= 3; t++) rd_chk("R5 s1 fill", mk(t, 1, 0), 1'b0);
        rd_chk("R5 s0 fill", mk(1, 0, 0), 1'b0);
        rd_chk("R5 s1 fill way3", mk(4, 1, 0), 1'b0);
        rd_chk("R5 s1 evict way0", mk(5, 1, 0), 1'b0);
        rd_chk("R5 own pointer keeps t2", mk(2, 1, 1), 1'b1);
        rd_chk("R5 own pointer keeps t3", mk(3, 1, 1), 1'b1);
        rd_chk("R5 t1 evicted", mk(1, 1, 0), 1'b0);
        rd_chk("R5 t2 evicted", mk(2, 1, 0), 1'b0);
        rd_chk("R5 t3 refill way3", mk(3, 1, 0), 1'b0);
        rd_chk("R5 t4 refill after wrap", mk(4, 1, 0), 1'b0);
        rd_chk("R5 t1 resident", mk(1, 1, 2), 1'b1);
        rd_chk("R5 t2 resident", mk(2, 1, 2), 1'b1);
        rd_chk("R5 t3 resident", mk(3, 1, 2), 1'b1);

        // R6: lockdown in round-robin mode
        do_reset();
        cfg(1'b1, 0);
        for (int t = 10; t <= 13; t++) rd_chk("R6 fill", mk(t, 0, 0), 1'b0);
        cfg(1'b1, 2);
        rd_chk("R6 miss t14", mk(14, 0, 0), 1'b0);
        rd_chk("R6 miss t15", mk(15, 0, 0), 1'b0);
        rd_chk("R6 miss t16 wraps to base", mk(16, 0, 0), 1'b0);
        rd_chk("R6 locked t10 kept", mk(10, 0, 3), 1'b1);
        rd_chk("R6 locked t11 kept", mk(11, 0, 3), 1'b1);
        rd_chk("R6 t15 kept", mk(15, 0, 3), 1'b1);
        rd_chk("R6 t16 kept", mk(16, 0, 3), 1'b1);
        rd_chk("R6 t12 evicted", mk(12, 0, 0), 1'b0);
        rd_chk("R6 t16 after t12 refill", mk(16, 0, 4), 1'b1);

        // R7: random replacement restricted by lock base
        do_reset();
        cfg(1'b1, 0);
        for (int t = 30; t <= 33; t++) rd_chk("R7 fill", mk(t, 0, 0), 1'b0);
        cfg(1'b0, 2);
        for (int t = 40; t <= 45; t++) rd_chk("R7 random miss", mk(t, 0, 0), 1'b0);
        rd_chk("R7 locked t30 kept", mk(30, 0, 1), 1'b1);
        rd_chk("R7 locked t31 kept", mk(31, 0, 1), 1'b1);
        cfg(1'b0, 3);
        rd_chk("R7 only way3 t50", mk(50, 0, 0), 1'b0);
        rd_chk("R7 only way3 t51", mk(51, 0, 0), 1'b0);
        rd_chk("R7 t51 resident", mk(51, 0, 1), 1'b1);
        rd_chk("R7 t50 displaced", mk(50, 0, 1), 1'b0);

        // R8: write hit updates cache and memory together
        b0 = n_burst; w0 = n_swr;
        access(mk(30, 0, 2), 1'b1, 32'hCAFE_0001, 1'b1, d, lat);
        chk("R8 write hit latency", 32'(lat), 32'd3);
        chk("R8 one memory write", 32'(n_swr - w0), 32'd1);
        chk("R8 write address", last_addr, mk(30, 0, 2));
        chk("R8 no fill on write", 32'(n_burst - b0), 32'd0);
        chk("R8 memory holds data", mem_val(mk(30, 0, 2)), 32'hCAFE_0001);
        rd_chk("R8 read back hit", mk(30, 0, 2), 1'b1);
        // R8: write miss does not allocate
        b0 = n_burst;
        access(mk(90, 1, 4), 1'b1, 32'hBEEF_0002, 1'b1, d, lat);
        chk("R8 write miss no fill", 32'(n_burst - b0), 32'd0);
        rd_chk("R8 line absent after write miss", mk(90, 1, 4), 1'b0);

        // R9: uncached read
        b0 = n_burst; r0 = n_srd;
        access(mk(91, 0, 0), 1'b0, '0, 1'b0, d, lat);
        chk("R9 uncached data", d, mem_val(mk(91, 0, 0)));
        chk("R9 uncached latency", 32'(lat), 32'd3);
        chk("R9 single read", 32'(n_srd - r0), 32'd1);
        chk("R9 no fill", 32'(n_burst - b0), 32'd0);
        rd_chk("R9 no allocation", mk(91, 0, 0), 1'b0);
        // R9: uncached write leaves the cached copy alone
        old = mem_val(mk(31, 0, 5));
        access(mk(31, 0, 5), 1'b1, 32'h1357_9BDF, 1'b0, d, lat);
        chk("R9 uncached write to memory", mem_val(mk(31, 0, 5)), 32'h1357_9BDF);
        b0 = n_burst;
        access(mk(31, 0, 5), 1'b0, '0, 1'b1, d, lat);
        chk("R9 cached copy unchanged", d, old);
        chk("R9 cached copy hit latency", 32'(lat), 32'd2);
        chk("R9 cached copy no fill", 32'(n_burst - b0), 32'd0);

        // R10: req_valid during a fill is ignored
        b0 = n_burst; r0 = n_srd + n_swr;
        @(negedge clk);
        req_valid = 1'b1; req_addr = mk(80, 1, 3); req_write = 1'b0; req_cacheable = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = mk(81, 0, 6);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!resp_ready && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        chk("R10 first request data", resp_rdata, mem_val(mk(80, 1, 3)));
        lat = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (resp_ready) lat++;
        end
        chk("R10 no extra response", 32'(lat), 32'd0);
        chk("R10 single fill only", 32'(n_burst - b0), 32'd1);
        chk("R10 no other transfer", 32'(n_srd + n_swr - r0), 32'd0);

        finish_run();
    end

endmodule